// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of clock cycles. It does not ripple every bit through a long register chain. Instead each incoming word is written once into a small two-port storage array and stays there until it is read out. A write pointer and a read pointer walk around that array in step, one entry per cycle. The array is inferred with one write port and one registered read port.

The stream needs no address and no handshake. A word enters on every clock and a word leaves on every clock, in the order they arrived. A synchronous reset parks the read pointer at entry zero and the write pointer at the highest entry. A flag marks the output as meaningful once the first word written after reset comes out. The delay is set at build time by the depth parameter, which must be a power of two.

Top module: `mem_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, the read pointer becomes entry 0, the write pointer becomes entry DEPTH-1, and after that edge `dout_valid` is 0 and `dout` is all zeros.
- R2: A word presented on `din` in the cycle that ends with the first rising edge after reset release appears on `dout` during the cycle that follows the DEPTH-th such edge. In general every word appears exactly DEPTH cycles after it was presented, and the arrival order is kept.
- R3: On every rising edge with `rst` low, both pointers advance by one, and each wraps from entry DEPTH-1 to entry 0.
- R4: `dout_valid` stays 0 for the first DEPTH-1 edges after reset release. It becomes 1 at the DEPTH-th edge, when the read pointer leaves entry DEPTH-1, and stays 1 until the next reset.
- R5: The read pointer and the write pointer never point at the same entry, so a read never collides with a write.
- R6: A reset applied in the middle of a stream discards every word in flight. `dout_valid` drops, and the next valid output is the first word presented after the reset was released.
- R7: Every bit of the word is carried. Words such as all ones, all zeros and alternating bit patterns come out exactly as they went in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Word entering the delay line this cycle |
| dout | output | WIDTH | Word that entered DEPTH cycles ago (registered read) |
| dout_valid | output | 1 | High once `dout` carries data written after reset |

## Verification
The embedded assertions check on every cycle that the pointers keep their one-entry gap and never coincide. They also check that the read pointer steps by one with wrap, that the valid flag never falls outside reset, and that it rises only as the read pointer leaves the top entry. Only the bench scenarios can show that data survives the trip intact and in order. This covers the exact DEPTH-cycle alignment of each word, full-width bit patterns, and a reset in mid-stream that flushes the words in flight and restarts the fill count.

// File: rtl/mem_delay_line.sv
module mem_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_valid
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wa, ra;
  logic [WIDTH-1:0] rdata;
  logic             vld;

  initial assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");

  always_ff @(posedge clk)
    if (!rst) store[wa] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra    <= '0;
      wa    <= TOP;
      rdata <= '0;
      vld   <= 1'b0;
    end else begin
      ra    <= ra + 1'b1;
      wa    <= wa + 1'b1;
      rdata <= store[ra];
      if (ra == TOP) vld <= 1'b1;
    end
  end

  assign dout       = rdata;
  assign dout_valid = vld;

  // R3 / R5: pointers hold a one-entry gap and never meet
  a_r5_no_collision: assert property (@(posedge clk) disable iff (rst)
    ra != wa);
  a_r3_gap: assert property (@(posedge clk) disable iff (rst)
    ra == AW'(wa + 1'b1));
  a_r3_rd_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ra == AW'($past(ra) + 1'b1));
  // R4: valid is sticky and rises only when the read pointer leaves the top entry
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid);
  a_r4_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_valid) |-> $past(ra) == TOP);
  // R1: reset clears the flag
  a_r1_reset: assert property (@(posedge clk)
    rst |=> !dout_valid && dout == '0);
endmodule

// File: tb/sim_mem_delay_line.sv
module sim_mem_delay_line;
  localparam int WIDTH = 8;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             dout_valid;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  logic [WIDTH-1:0] q[$];
  string tag = "R2";

  always #2 clk = ~clk;

  mem_delay_line #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .dout_valid(dout_valid));

  always @(posedge clk)
    if (rst) edges <= 0; else edges <= edges + 1;

  // monitor: compare outputs away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (dout_valid !== (edges >= DEPTH)) begin
        errors++;
        $display("FAIL R4 valid after %0d edges: actual %b expected %b",
                 edges, dout_valid, edges >= DEPTH);
      end
      if (dout_valid) begin
        logic [WIDTH-1:0] exp;
        exp = q.pop_front();
        checks++;
        if (dout !== exp) begin
          errors++;
          $display("FAIL %s data: actual %h expected %h", tag, dout, exp);
        end
      end
    end
  end

  task automatic drive(input logic [WIDTH-1:0] v);
    din = v;
    q.push_back(v);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    q.delete();
    @(posedge clk); #1;
    checks++;
    if (dout_valid !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual valid %b dout %h expected 0 00",
               dout_valid, dout);
    end
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    do_reset();
    tag = "R2";
    for (int i = 0; i < 3 * DEPTH; i++) drive(WIDTH'(i * 7 + 1));
    tag = "R7";
    for (int i = 0; i < 2 * DEPTH; i++)
      case (i % 4)
        0: drive('1);
        1: drive('0);
        2: drive(8'hA5);
        default: drive(8'h5A);
      endcase
    tag = "R6";
    for (int i = 0; i < 5; i++) drive(8'hEE);
    do_reset();
    for (int i = 0; i < 2 * DEPTH + 3; i++) drive(WIDTH'(8'h40 + i));
    tag = "R3";
    for (int i = 0; i < 4 * DEPTH; i++) drive(WIDTH'(i ^ 8'h3C));
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule